// File: doc/BRIEF.md
# Memory Write-Protection Status Unit

This unit sits beside the serial command engine of a non-volatile serial memory and owns every decision about whether a write may land. It holds the write-enable latch, a lock bit and a two-bit protected-zone field. It also samples the active-low hardware write-protect pin. The serial engine reports decoded events to it as single-cycle pulses: enable-write, disable-write, status-register write, memory write attempt, and the chip-select falling and rising edges. The unit answers with two combinational grants, one for the memory array and one for the status register. It also supplies the status byte that the engine shifts out on a status read.

Protection works in two tiers. The zone field blocks fixed regions of the address space from memory writes. The lock bit, together with the write-protect pin, guards the zone field and the lock bit itself. When the lock bit is set, the zone covers everything and the pin is held low, software alone cannot make any write succeed.

Top module: `wp_guard`

## Requirements
- R1: A `cmd_wren` pulse sets the write-enable latch (status bit 1) on the next clock edge, and a `cmd_wrdi` pulse clears it. When both pulse in the same cycle, the latch ends up clear.
- R2: A `cs_rise` pulse clears the write-enable latch only if a memory write attempt or a status write request arrived since the last `cs_fall`. A `cs_rise` after a session with no write attempt leaves the latch unchanged.
- R3: While the write-enable latch is clear, `mem_wr_ok` and `sr_wr_ok` are both 0.
- R4: While the lock bit (status bit 7) is 0, the write-protect pin has no effect, and `sr_wr_ok` equals the write-enable latch.
- R5: While the lock bit is 1 and the latched pin value is 0, `sr_wr_ok` is 0 and a status write request leaves the status byte unchanged.
- R6: The zone field is status bits 3:2. With a 15-bit address, zone 00 protects nothing, 01 protects 6000h–7FFFh, 10 protects 4000h–7FFFh and 11 protects every address. `mem_wr_ok` is 1 exactly when the latch is set and `mem_addr` is outside the protected range.
- R7: The pin is sampled into an internal copy on each `cs_fall`. A change of the pin within a session does not alter `sr_wr_ok` until the next `cs_fall`.
- R8: The status byte is {lock, 3'b000, zone[1:0], wel, 1'b0}. A granted status write loads only bits 7, 3 and 2 from `sr_wr_data`, on the next edge.
- R9: After reset, the write-enable latch is 0, the lock bit and the zone field take the values of `INIT_LOCK` and `INIT_ZONE` (default 0), and the pin copy reads 1 (unprotected).
- R10: The lock bit and the pin never change `mem_wr_ok`. Only the zone field and the latch gate memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_fall | input | 1 | Chip-select falling edge seen (pulse) |
| cs_rise | input | 1 | Chip-select rising edge seen (pulse) |
| cmd_wren | input | 1 | Enable-write command decoded (pulse) |
| cmd_wrdi | input | 1 | Disable-write command decoded (pulse) |
| sr_wr_req | input | 1 | Status-register write request (pulse) |
| sr_wr_data | input | 8 | Byte offered for the status write |
| mem_wr_chk | input | 1 | Memory write attempt at `mem_addr` (pulse) |
| mem_addr | input | ADDR_W | Memory address being checked |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| mem_wr_ok | output | 1 | Memory write at `mem_addr` permitted |
| sr_wr_ok | output | 1 | Status-register write permitted |
| status_byte | output | 8 | Status byte for reads |

## Verification
The bench probes both edges of every zone boundary: 5FFFh against 6000h, 3FFFh against 4000h, and address 0 under full protection. A decoder that is off by one bit would grant or refuse the wrong byte at these edges. It flips the write-protect pin in the middle of a locked session and expects the grant to stay refused. A design that reads the live pin instead of the latched copy would unlock at that point. It ends one session with a write attempt and another without one. A design that clears the latch on every chip-select rise fails the second case. It also writes a byte with the reserved bits set and sets the lock with the pin low. This catches designs that leak reserved bits or that let the pin gate memory writes.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    // write-enable latch state and chip-select session tracking
    typedef struct packed {
        logic wel;      // write-enable latch
        logic wr_seen;  // a write attempt happened in this session
        logic pin_lat;  // pin value captured at session start
    } latch_st_t;

    // software-visible protection fields
    typedef struct packed {
        logic       lock;
        logic [1:0] zone;
    } prot_st_t;

    localparam int STAT_LOCK_BIT = 7;
    localparam int STAT_ZONE_HI  = 3;
    localparam int STAT_ZONE_LO  = 2;
    localparam int STAT_WEL_BIT  = 1;

    function automatic logic [7:0] pack_status(prot_st_t p, logic wel);
        logic [7:0] s;
        s = '0;
        s[STAT_LOCK_BIT]              = p.lock;
        s[STAT_ZONE_HI:STAT_ZONE_LO]  = p.zone;
        s[STAT_WEL_BIT]               = wel;
        return s;
    endfunction

endpackage

// File: rtl/wp_latch_ctrl.sv
module wp_latch_ctrl
    import wp_guard_pkg::*;
#(
    parameter logic PIN_RST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic cmd_wren,
    input  logic cmd_wrdi,
    input  logic wr_attempt,
    input  logic wp_n,
    output logic wel,
    output logic pin_lat
);

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            st_d.pin_lat = wp_n;
            st_d.wr_seen = 1'b0;
        end
        if (wr_attempt) begin
            st_d.wr_seen = 1'b1;
        end
        if (cs_rise && st_q.wr_seen) begin
            st_d.wel     = 1'b0;
            st_d.wr_seen = 1'b0;
        end
        if (cmd_wren) begin
            st_d.wel = 1'b1;
        end
        if (cmd_wrdi) begin
            st_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wel: 1'b0, wr_seen: 1'b0, pin_lat: PIN_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign wel     = st_q.wel;
    assign pin_lat = st_q.pin_lat;

endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
    import wp_guard_pkg::*;
#(
    parameter logic       INIT_LOCK = 1'b0,
    parameter logic [1:0] INIT_ZONE = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel,
    input  logic       pin_lat,
    input  logic       sr_wr_req,
    input  logic [7:0] sr_wr_data,
    output logic       sr_wr_ok,
    output prot_st_t   prot
);

    prot_st_t prot_d, prot_q;
    logic     pin_guard;

    // the pin only matters while the lock bit is set
    assign pin_guard = prot_q.lock & ~pin_lat;
    assign sr_wr_ok  = wel & ~pin_guard;

    always_comb begin
        prot_d = prot_q;
        if (sr_wr_req && sr_wr_ok) begin
            prot_d.lock = sr_wr_data[STAT_LOCK_BIT];
            prot_d.zone = sr_wr_data[STAT_ZONE_HI:STAT_ZONE_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= '{lock: INIT_LOCK, zone: INIT_ZONE};
        end else begin
            prot_q <= prot_d;
        end
    end

    assign prot = prot_q;

endmodule

// File: rtl/wp_zone_decode.sv
module wp_zone_decode #(
    parameter int ADDR_W = 15
) (
    input  logic [1:0]        zone,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wel,
    output logic              mem_wr_ok
);

    localparam int TOP = ADDR_W - 1;

    logic hit;

    generate
        if (ADDR_W >= 2) begin : g_wide
            always_comb begin
                unique case (zone)
                    2'b00:   hit = 1'b0;
                    2'b01:   hit = &addr[TOP -: 2];
                    2'b10:   hit = addr[TOP];
                    default: hit = 1'b1;
                endcase
            end
        end else begin : g_narrow
            always_comb begin
                unique case (zone)
                    2'b00:   hit = 1'b0;
                    2'b01:   hit = 1'b0;
                    2'b10:   hit = addr[TOP];
                    default: hit = 1'b1;
                endcase
            end
        end
    endgenerate

    assign mem_wr_ok = wel & ~hit;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int         ADDR_W    = 15,
    parameter logic       INIT_LOCK = 1'b0,
    parameter logic [1:0] INIT_ZONE = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              sr_wr_req,
    input  logic [7:0]        sr_wr_data,
    input  logic              mem_wr_chk,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              wp_n,
    output logic              mem_wr_ok,
    output logic              sr_wr_ok,
    output logic [7:0]        status_byte
);

    logic     wel;
    logic     pin_lat;
    logic     wr_attempt;
    prot_st_t prot;

    assign wr_attempt = mem_wr_chk | sr_wr_req;

    wp_latch_ctrl #(
        .PIN_RST (1'b1)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .cmd_wren   (cmd_wren),
        .cmd_wrdi   (cmd_wrdi),
        .wr_attempt (wr_attempt),
        .wp_n       (wp_n),
        .wel        (wel),
        .pin_lat    (pin_lat)
    );

    wp_status_reg #(
        .INIT_LOCK (INIT_LOCK),
        .INIT_ZONE (INIT_ZONE)
    ) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .wel        (wel),
        .pin_lat    (pin_lat),
        .sr_wr_req  (sr_wr_req),
        .sr_wr_data (sr_wr_data),
        .sr_wr_ok   (sr_wr_ok),
        .prot       (prot)
    );

    wp_zone_decode #(
        .ADDR_W (ADDR_W)
    ) u_zone (
        .zone      (prot.zone),
        .addr      (mem_addr),
        .wel       (wel),
        .mem_wr_ok (mem_wr_ok)
    );

    assign status_byte = pack_status(prot, wel);

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       sr_wr_req,
    input logic       mem_wr_ok,
    input logic       sr_wr_ok,
    input logic [7:0] status_byte
);

    AST_WREN_SETS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi) |=> status_byte[1]);                          // R1

    AST_WRDI_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrdi |=> !status_byte[1]);                                         // R1

    AST_NO_WEL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[1] |-> (!mem_wr_ok && !sr_wr_ok));                        // R3

    AST_UNLOCKED_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_byte[7] && status_byte[1]) |-> sr_wr_ok);                     // R4

    AST_BLOCKED_SR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req && !sr_wr_ok) |=> $stable(status_byte[7:2]));               // R5

    AST_FULL_ZONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_wr_ok);                           // R6

endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wren    (cmd_wren),
    .cmd_wrdi    (cmd_wrdi),
    .sr_wr_req   (sr_wr_req),
    .mem_wr_ok   (mem_wr_ok),
    .sr_wr_ok    (sr_wr_ok),
    .status_byte (status_byte)
);

// File: tb/tb_wp_guard.sv
module tb_wp_guard;

    localparam int AW = 15;

    localparam logic [2:0] OP_NOP  = 3'd0;
    localparam logic [2:0] OP_CSF  = 3'd1;
    localparam logic [2:0] OP_CSR  = 3'd2;
    localparam logic [2:0] OP_WREN = 3'd3;
    localparam logic [2:0] OP_WRDI = 3'd4;
    localparam logic [2:0] OP_SRW  = 3'd5;
    localparam logic [2:0] OP_MCK  = 3'd6;

    typedef struct packed {
        logic [2:0]    op;
        logic [7:0]    data;
        logic [AW-1:0] addr;
        logic          pin;
        logic          mem;
        logic          sr;
        logic [7:0]    st;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        '{OP_CSF , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h00}, // R7 session start
        '{OP_MCK , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h00}, // R3
        '{OP_WREN, 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h02}, // R1
        '{OP_MCK , 8'h00, 15'h7FFF, 1'b1, 1'b1, 1'b1, 8'h02}, // R6 zone 00
        '{OP_CSR , 8'h00, 15'h7FFF, 1'b1, 1'b1, 1'b1, 8'h00}, // R2
        '{OP_CSF , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h00},
        '{OP_WREN, 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h02},
        '{OP_SRW , 8'hFF, 15'h0000, 1'b1, 1'b1, 1'b1, 8'h8E}, // R8
        '{OP_MCK , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b1, 8'h8E}, // R6 zone 11
        '{OP_CSR , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b1, 8'h8C}, // R2
        '{OP_CSF , 8'h00, 15'h0000, 1'b0, 1'b0, 1'b0, 8'h8C}, // R7 latch pin low
        '{OP_WREN, 8'h00, 15'h0000, 1'b0, 1'b0, 1'b0, 8'h8E},
        '{OP_SRW , 8'h00, 15'h0000, 1'b0, 1'b0, 1'b0, 8'h8E}, // R5
        '{OP_MCK , 8'h00, 15'h7FFF, 1'b1, 1'b0, 1'b0, 8'h8E}, // R7 pin rises mid-session
        '{OP_CSR , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h8C},
        '{OP_CSF , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h8C}, // R7 latch pin high
        '{OP_WREN, 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h8E},
        '{OP_SRW , 8'h04, 15'h0000, 1'b1, 1'b0, 1'b1, 8'h06}, // R8 zone 01
        '{OP_MCK , 8'h00, 15'h5FFF, 1'b1, 1'b1, 1'b1, 8'h06}, // R6 below quarter
        '{OP_MCK , 8'h00, 15'h6000, 1'b1, 1'b0, 1'b1, 8'h06}, // R6 quarter edge
        '{OP_SRW , 8'h78, 15'h0000, 1'b1, 1'b1, 1'b1, 8'h0A}, // R8 reserved bits dropped
        '{OP_MCK , 8'h00, 15'h3FFF, 1'b1, 1'b1, 1'b1, 8'h0A}, // R6 below half
        '{OP_MCK , 8'h00, 15'h4000, 1'b1, 1'b0, 1'b1, 8'h0A}, // R6 half edge
        '{OP_WRDI, 8'h00, 15'h0000, 1'b1, 1'b1, 1'b1, 8'h08}, // R1
        '{OP_MCK , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h08}, // R3
        '{OP_WREN, 8'h00, 15'h0000, 1'b0, 1'b0, 1'b0, 8'h0A},
        '{OP_SRW , 8'h80, 15'h0000, 1'b0, 1'b1, 1'b1, 8'h82}, // R4
        '{OP_MCK , 8'h00, 15'h7FFF, 1'b0, 1'b1, 1'b1, 8'h82}, // R10, R7
        '{OP_CSR , 8'h00, 15'h0000, 1'b1, 1'b1, 1'b1, 8'h80}, // R2
        '{OP_CSR , 8'h00, 15'h0000, 1'b1, 1'b0, 1'b0, 8'h80},
        '{OP_CSF , 8'h00, 15'h0000, 1'b0, 1'b0, 1'b0, 8'h80},
        '{OP_WREN, 8'h00, 15'h0000, 1'b0, 1'b0, 1'b0, 8'h82},
        '{OP_NOP , 8'h00, 15'h0000, 1'b0, 1'b1, 1'b0, 8'h82}, // R10, R5
        '{OP_CSR , 8'h00, 15'h0000, 1'b0, 1'b1, 1'b0, 8'h82}, // R2 no attempt
        '{OP_WRDI, 8'h00, 15'h0000, 1'b0, 1'b1, 1'b0, 8'h80},
        '{OP_NOP , 8'h00, 15'h0000, 1'b0, 1'b0, 1'b0, 8'h80}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_fall = 1'b0, cs_rise = 1'b0, cmd_wren = 1'b0, cmd_wrdi = 1'b0;
    logic          sr_wr_req = 1'b0, mem_wr_chk = 1'b0, wp_n = 1'b1;
    logic [7:0]    sr_wr_data = '0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_wr_ok, sr_wr_ok;
    logic [7:0]    status_byte;
    logic          i_mem, i_sr;
    logic [7:0]    i_status;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    wp_guard #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .sr_wr_req(sr_wr_req),
        .sr_wr_data(sr_wr_data), .mem_wr_chk(mem_wr_chk), .mem_addr(mem_addr),
        .wp_n(wp_n), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok),
        .status_byte(status_byte)
    );

    wp_guard #(.ADDR_W(AW), .INIT_LOCK(1'b1), .INIT_ZONE(2'b11)) dut_init (
        .clk(clk), .rst_n(rst_n), .cs_fall(1'b0), .cs_rise(1'b0),
        .cmd_wren(1'b0), .cmd_wrdi(1'b0), .sr_wr_req(1'b0),
        .sr_wr_data(8'h00), .mem_wr_chk(1'b0), .mem_addr('0),
        .wp_n(1'b1), .mem_wr_ok(i_mem), .sr_wr_ok(i_sr),
        .status_byte(i_status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        cs_fall = 0; cs_rise = 0; cmd_wren = 0; cmd_wrdi = 0;
        sr_wr_req = 0; mem_wr_chk = 0; sr_wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state on both instances
        check("R9 status", status_byte, 8'h00);
        check("R9 grants", {6'b0, mem_wr_ok, sr_wr_ok}, 8'h00);
        check("R9 init params", i_status, 8'h8C);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 status after release", status_byte, 8'h00);

        for (int i = 0; i < NV; i++) begin
            clear_inputs();
            wp_n       = VEC[i].pin;
            mem_addr   = VEC[i].addr;
            sr_wr_data = VEC[i].data;
            unique case (VEC[i].op)
                OP_CSF:  cs_fall    = 1'b1;
                OP_CSR:  cs_rise    = 1'b1;
                OP_WREN: cmd_wren   = 1'b1;
                OP_WRDI: cmd_wrdi   = 1'b1;
                OP_SRW:  sr_wr_req  = 1'b1;
                OP_MCK:  mem_wr_chk = 1'b1;
                default: ;
            endcase
            #1;
            check($sformatf("R6/R10 mem_wr_ok vec %0d", i), {7'b0, mem_wr_ok}, {7'b0, VEC[i].mem});
            check($sformatf("R4/R5 sr_wr_ok vec %0d", i), {7'b0, sr_wr_ok}, {7'b0, VEC[i].sr});
            @(negedge clk);
            check($sformatf("R8 status vec %0d", i), status_byte, VEC[i].st);
        end
        clear_inputs();

        // R1 enable and disable in the same cycle: disable wins
        cmd_wren = 1'b1;
        cmd_wrdi = 1'b1;
        @(negedge clk);
        clear_inputs();
        check("R1 wren+wrdi same cycle", status_byte, 8'h80);

        // R3 latch clear: no grant at an unprotected address
        mem_addr = '0;
        #1;
        check("R3 no latch no grant", {6'b0, mem_wr_ok, sr_wr_ok}, 8'h00);

        finish_run();
    end

endmodule